// File: doc/BRIEF.md
# Load/Store Sequencer with Block Register Transfer

This block carries out memory accesses on behalf of a processor pipeline. A single command moves one byte, half-word or word between a register and memory; a block command moves a contiguous run of registers, from a chosen starting index up to the highest register index, to or from consecutive memory words. Narrow loads pick the addressed byte lanes out of the memory word and fill the upper bits with zeros. Narrow stores copy the source value across every lane and mark the written lanes with byte enables.

Commands arrive on a valid/ready port. The port accepts a command only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low for as long as a transfer is in flight, so a producer holds its command until the block goes idle. The memory port and the register-file port carry no back-pressure. Memory answers a read in the cycle after the request. The register file returns read data in the cycle after `rf_re`.

A command whose address does not suit its size is rejected. One cycle after it is accepted, the block pulses `fault` and makes no access. A block transfer of N registers keeps the unit busy for N+1 cycles, because the fetch of each register overlaps the completion of the one before it.

Top module: `lsu_xfer`

## Requirements
- R1: Stores write `mem_be`/`mem_wdata` by size. `cmd_size` 0 is byte, 1 is half-word, 2 or 3 is word. A byte store sets only `mem_be` bit addr[1:0] and repeats the register's low byte in all four lanes. A half-word store sets `mem_be` to 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1, and repeats the low half in both halves. A word store sets 4'b1111 and writes the register unchanged.
- R2: A load writes the register with the selected lane zero-extended to 32 bits. Bytes come from bits 8*addr[1:0]+7 down to 8*addr[1:0]. Half-words come from the upper half when addr[1]=1 and from the lower half otherwise. Words are written unchanged.
- R3: A single load (`cmd_op` 0) or store (`cmd_op` 1) keeps `busy` high for exactly 2 cycles. A load reads memory in busy cycle 1 and writes the register in busy cycle 2. A store reads the register in cycle 1 and writes memory in cycle 2.
- R4: A block load (`cmd_op` 2) or block store (`cmd_op` 3) starting at register S covers S..NREGS-1, N = NREGS-S registers. The k-th register (k from 0) uses address base+4k, and its write lands in busy cycle k+2. `busy` is high for exactly N+1 cycles.
- R5: Block transfers always move full words (`mem_be` = 4'b1111) whatever `cmd_size` holds.
- R6: A misaligned command raises `fault` for one cycle, one cycle after acceptance, and makes no access. A half-word is misaligned when addr[0]=1. A word or block command is misaligned when addr[1:0]≠0. After the fault the block stays idle.
- R7: `cmd_ready` is low in every cycle where `busy` is high, and a register write and a memory write never occur in the same cycle.
- R8: After reset, `cmd_ready` is 1 and `busy`, `fault`, `mem_req`, `rf_we` and `rf_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_op | input | 2 | 0 load, 1 store, 2 block load, 3 block store |
| cmd_size | input | 2 | 0 byte, 1 half-word, 2/3 word (single ops only) |
| cmd_addr | input | AW | Byte address or block base address |
| cmd_reg | input | RW | Register index or block start index |
| fault | output | 1 | One-cycle pulse for a rejected misaligned command |
| busy | output | 1 | Transfer in flight |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rf_re | output | 1 | Register read request |
| rf_raddr | output | RW | Register read index |
| rf_rdata | input | 32 | Register data, valid the cycle after `rf_re` |
| rf_we | output | 1 | Register write |
| rf_waddr | output | RW | Register write index |
| rf_wdata | output | 32 | Register write data |

## Verification
Inside a block transfer, two operations fall in the same cycle: the fetch of register k+1 and the completion of register k. In a block store these are a register read and a memory write; in a block load they are a memory read and a register write. The bench runs block transfers of one, three and four registers. For each write it records the busy-cycle index, address and data. It then checks that every write pairs the right register with the right address and falls in cycle k+2, so a slip of one stage against the other shows up as a wrong pairing or a wrong count.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] OP_LOAD   = 2'd0;
  localparam logic [1:0] OP_STORE  = 2'd1;
  localparam logic [1:0] OP_LOADM  = 2'd2;
  localparam logic [1:0] OP_STOREM = 2'd3;

  function automatic logic bad_align(input logic [1:0] op, input logic [1:0] size,
                                     input logic [1:0] lo);
    logic wordish;
    wordish = op[1] || size[1];
    return wordish ? (lo != 2'b00) : ((size == SZ_HALF) && lo[0]);
  endfunction
endpackage

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        be_addr,
  input  logic [1:0]        ld_addr,
  input  logic [DATA_W-1:0] st_src,
  input  logic [DATA_W-1:0] ld_src,
  output logic [DATA_W-1:0] st_data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] ld_data
);
  logic is_byte, is_half;
  assign is_byte = (size == SZ_BYTE);
  assign is_half = (size == SZ_HALF);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [1:0] IDX = 2'(i);
    assign be[i] = (!is_byte && !is_half)
                 || (is_half && (be_addr[1] == IDX[1]))
                 || (is_byte && (be_addr == IDX));
  end

  always_comb begin
    if (is_byte)      st_data = {LANES{st_src[7:0]}};
    else if (is_half) st_data = {2{st_src[15:0]}};
    else              st_data = st_src;
  end

  logic [DATA_W-1:0] shifted;
  assign shifted = ld_src >> {ld_addr, 3'b000};

  always_comb begin
    if (is_byte)      ld_data = {{(DATA_W-8){1'b0}}, shifted[7:0]};
    else if (is_half) ld_data = {{(DATA_W-16){1'b0}}, shifted[15:0]};
    else              ld_data = ld_src;
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREGS = 16,
  localparam int RW   = $clog2(NREGS)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    start_op,
  input  logic [1:0]    start_size,
  input  logic [AW-1:0] start_addr,
  input  logic [RW-1:0] start_reg,
  output logic          a_act,
  output logic [AW-1:0] a_addr,
  output logic [RW-1:0] a_reg,
  output logic          b_act,
  output logic [AW-1:0] b_addr,
  output logic [RW-1:0] b_reg,
  output logic          x_store,
  output logic          x_multi,
  output logic [1:0]    x_size
);
  localparam logic [RW-1:0] LAST_IDX = RW'(NREGS - 1);
  localparam logic [AW-1:0] STEP     = AW'(4);

  logic a_last;
  assign a_last = !x_multi || (a_reg == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_act   <= 1'b0;
      b_act   <= 1'b0;
      a_addr  <= '0;
      a_reg   <= '0;
      b_addr  <= '0;
      b_reg   <= '0;
      x_store <= 1'b0;
      x_multi <= 1'b0;
      x_size  <= SZ_WORD;
    end else begin
      b_act <= a_act;
      if (a_act) begin
        b_addr <= a_addr;
        b_reg  <= a_reg;
      end
      if (start) begin
        a_act   <= 1'b1;
        a_addr  <= start_addr;
        a_reg   <= start_reg;
        x_store <= start_op[0];
        x_multi <= start_op[1];
        x_size  <= start_op[1] ? SZ_WORD : start_size;
      end else if (a_act) begin
        if (a_last) begin
          a_act <= 1'b0;
        end else begin
          a_addr <= a_addr + STEP;
          a_reg  <= a_reg + 1'b1;
        end
      end
    end
  end

  a_r4_reg_step: assert property (@(posedge clk) disable iff (!rst_n)
    (a_act && b_act && x_multi) |-> (a_reg == b_reg + 1'b1 && a_addr == b_addr + STEP));
endmodule

// File: rtl/lsu_xfer.sv
module lsu_xfer
  import lsu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREGS = 16,
  localparam int RW   = $clog2(NREGS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_size,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [RW-1:0]     cmd_reg,
  output logic              fault,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rf_re,
  output logic [RW-1:0]     rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [RW-1:0]     rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic          a_act, b_act, x_store, x_multi;
  logic [AW-1:0] a_addr, b_addr;
  logic [RW-1:0] a_reg, b_reg;
  logic [1:0]    x_size;
  logic          take, misalign, start;

  assign busy      = a_act || b_act;
  assign cmd_ready = !busy;
  assign take      = cmd_valid && cmd_ready;
  assign misalign  = bad_align(cmd_op, cmd_size, cmd_addr[1:0]);
  assign start     = take && !misalign;

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= take && misalign;
  end

  lsu_seq #(.AW(AW), .NREGS(NREGS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_op(cmd_op), .start_size(cmd_size), .start_addr(cmd_addr), .start_reg(cmd_reg),
    .a_act(a_act), .a_addr(a_addr), .a_reg(a_reg),
    .b_act(b_act), .b_addr(b_addr), .b_reg(b_reg),
    .x_store(x_store), .x_multi(x_multi), .x_size(x_size)
  );

  logic [DATA_W-1:0] st_data, ld_data;
  logic [LANES-1:0]  lane_be;

  lsu_lane u_lane (
    .size(x_size),
    .be_addr(x_store ? b_addr[1:0] : a_addr[1:0]),
    .ld_addr(b_addr[1:0]),
    .st_src(rf_rdata), .ld_src(mem_rdata),
    .st_data(st_data), .be(lane_be), .ld_data(ld_data)
  );

  assign mem_req   = x_store ? b_act : a_act;
  assign mem_we    = x_store && b_act;
  assign mem_addr  = x_store ? b_addr : a_addr;
  assign mem_be    = lane_be;
  assign mem_wdata = st_data;
  assign rf_re     = x_store && a_act;
  assign rf_raddr  = a_reg;
  assign rf_we     = !x_store && b_act;
  assign rf_waddr  = b_reg;
  assign rf_wdata  = ld_data;

  a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && x_size == SZ_BYTE) |-> (rf_wdata[DATA_W-1:8] == '0));
  a_r2_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && x_size == SZ_HALF) |-> (rf_wdata[DATA_W-1:16] == '0));
  a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && x_size == SZ_BYTE) |-> ($countones(mem_be) == 1));
  a_r5_block_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && x_multi) |-> (mem_be == '1));
  a_r3_store_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rf_re));
  a_r3_load_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(mem_req && !mem_we));
  a_r6_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);
  a_r7_no_mix: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we));
endmodule

// File: tb/lsu_xfer_test.sv
module lsu_xfer_test;
  localparam int AW = 32;
  localparam int NREGS = 16;
  localparam int RW = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0, cmd_size = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [RW-1:0] cmd_reg = 0;
  logic fault, busy, mem_req, mem_we, rf_re, rf_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata = 0, rf_rdata = 0, rf_wdata;
  logic [RW-1:0] rf_raddr, rf_waddr;

  lsu_xfer #(.AW(AW), .NREGS(NREGS)) uut (.*);

  function automatic logic [31:0] memval(input logic [31:0] a);
    return 32'hF1E2D3C4 + {a[31:2], 2'b00};
  endfunction
  function automatic logic [31:0] rfval(input logic [RW-1:0] i);
    return 32'h11223344 + 32'({28'd0, i}) * 32'h01010101;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= memval(mem_addr);
    if (rf_re) rf_rdata <= rfval(rf_raddr);
  end

  int tests = 0, fails = 0;
  int bcnt, fcnt, rdy_bad, nrf, nmem;
  logic [31:0] r_addr [16], r_data [16];
  logic [3:0]  r_be [16];
  int          r_cyc [16];

  always @(negedge clk) begin
    if (busy) begin
      bcnt++;
      if (cmd_ready) rdy_bad++;
    end
    if (fault) fcnt++;
    if (rf_we && nrf + nmem < 16) begin
      r_addr[nrf + nmem] = {28'd0, rf_waddr}; r_data[nrf + nmem] = rf_wdata;
      r_be[nrf + nmem] = 4'h0; r_cyc[nrf + nmem] = bcnt; nrf++;
    end
    if (mem_req && mem_we && nrf + nmem < 16) begin
      r_addr[nrf + nmem] = mem_addr; r_data[nrf + nmem] = mem_wdata;
      r_be[nrf + nmem] = mem_be; r_cyc[nrf + nmem] = bcnt; nmem++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] a,
                     input logic [RW-1:0] rg);
    @(negedge clk); #1;
    bcnt = 0; fcnt = 0; nrf = 0; nmem = 0;
    cmd_valid = 1; cmd_op = op; cmd_size = sz; cmd_addr = a; cmd_reg = rg;
    @(negedge clk); #1;
    cmd_valid = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (!busy) break;
    end
  endtask

  typedef struct packed {
    logic [1:0] op; logic [1:0] sz; logic [31:0] addr; logic [3:0] rg;
    logic [31:0] data; logic [3:0] be; logic flt;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{2'd0, 2'd0, 32'h100, 4'd3, 32'h000000C4, 4'h0, 1'b0},
    '{2'd0, 2'd0, 32'h101, 4'd3, 32'h000000D4, 4'h0, 1'b0},
    '{2'd0, 2'd0, 32'h102, 4'd4, 32'h000000E2, 4'h0, 1'b0},
    '{2'd0, 2'd0, 32'h103, 4'd4, 32'h000000F1, 4'h0, 1'b0},
    '{2'd0, 2'd1, 32'h100, 4'd6, 32'h0000D4C4, 4'h0, 1'b0},
    '{2'd0, 2'd1, 32'h102, 4'd6, 32'h0000F1E2, 4'h0, 1'b0},
    '{2'd0, 2'd2, 32'h100, 4'd7, 32'hF1E2D4C4, 4'h0, 1'b0},
    '{2'd1, 2'd0, 32'h101, 4'd5, 32'h49494949, 4'b0010, 1'b0},
    '{2'd1, 2'd0, 32'h103, 4'd5, 32'h49494949, 4'b1000, 1'b0},
    '{2'd1, 2'd1, 32'h102, 4'd2, 32'h35463546, 4'b1100, 1'b0},
    '{2'd1, 2'd1, 32'h100, 4'd2, 32'h35463546, 4'b0011, 1'b0},
    '{2'd1, 2'd2, 32'h104, 4'd5, 32'h16273849, 4'b1111, 1'b0},
    '{2'd0, 2'd1, 32'h101, 4'd1, 32'h0, 4'h0, 1'b1},
    '{2'd0, 2'd2, 32'h102, 4'd1, 32'h0, 4'h0, 1'b1},
    '{2'd1, 2'd3, 32'h106, 4'd1, 32'h0, 4'h0, 1'b1}
  };

  task automatic block(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] base,
                       input logic [RW-1:0] s);
    int n;
    n = NREGS - int'(s);
    run(op, sz, base, s);
    chk(bcnt == n + 1, "R4 busy cycles", bcnt, n + 1);
    chk(nrf + nmem == n, "R4 write count", nrf + nmem, n);
    for (int k = 0; k < n; k++) begin
      logic [RW-1:0] ri;
      ri = s + RW'(k);
      chk(r_cyc[k] == k + 2, "R4 write cycle", r_cyc[k], k + 2);
      if (op == 2'd2) begin
        chk(r_addr[k] == {28'd0, ri}, "R4 load reg index", r_addr[k], {28'd0, ri});
        chk(r_data[k] == memval(base + 4 * k), "R4 load data", r_data[k], memval(base + 4 * k));
      end else begin
        chk(r_addr[k] == base + 4 * k, "R4 store address", r_addr[k], base + 4 * k);
        chk(r_data[k] == rfval(ri), "R4 store data", r_data[k], rfval(ri));
        chk(r_be[k] == 4'hF, "R5 full word lanes", r_be[k], 4'hF);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(cmd_ready == 1 && busy == 0 && fault == 0, "R8 idle flags", {cmd_ready, busy, fault}, 3'b100);
    chk(mem_req == 0 && rf_we == 0 && rf_re == 0, "R8 no access", {mem_req, rf_we, rf_re}, 0);
    @(negedge clk); rst_n = 1;

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      run(v.op, v.sz, v.addr, v.rg);
      if (v.flt) begin
        chk(fcnt == 1, "R6 fault pulse", fcnt, 1);
        chk(nrf + nmem == 0 && bcnt == 0, "R6 no access", nrf + nmem + bcnt, 0);
      end else begin
        chk(fcnt == 0, "R6 no spurious fault", fcnt, 0);
        chk(bcnt == 2, "R3 busy cycles", bcnt, 2);
        chk(r_cyc[0] == 2, "R3 write cycle", r_cyc[0], 2);
        if (v.op == 2'd0) begin
          chk(nrf == 1 && nmem == 0, "R3 one reg write", nrf, 1);
          chk(r_addr[0] == {28'd0, v.rg}, "R2 load reg index", r_addr[0], {28'd0, v.rg});
          chk(r_data[0] == v.data, "R2 load zero-extended", r_data[0], v.data);
        end else begin
          chk(nmem == 1 && nrf == 0, "R3 one mem write", nmem, 1);
          chk(r_addr[0] == v.addr, "R1 store address", r_addr[0], v.addr);
          chk(r_be[0] == v.be, "R1 store lanes", r_be[0], v.be);
          chk(r_data[0] == v.data, "R1 store data", r_data[0], v.data);
        end
      end
    end

    block(2'd2, 2'd2, 32'h200, 4'd12);
    block(2'd3, 2'd2, 32'h280, 4'd13);
    block(2'd2, 2'd0, 32'h2C0, 4'd15);
    block(2'd3, 2'd0, 32'h300, 4'd14);   // R5: byte size field ignored
    run(2'd2, 2'd2, 32'h202, 4'd8);
    chk(fcnt == 1, "R6 block misaligned fault", fcnt, 1);
    chk(nrf + nmem == 0 && bcnt == 0, "R6 block no access", nrf + nmem + bcnt, 0);
    chk(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
    chk(cmd_ready == 1, "R7 ready after finish", cmd_ready, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule